// File: doc/BRIEF.md
# Flash Sector Protection and Setup Register Block

This block is the register file that sits next to a flash controller and decides which sectors software may change. It keeps one 32-bit protection mask for each of two flash banks. Each bit stands for a 4 kB sector, so one mask covers 128 kB. A mask bit only ever moves from 1 (writable) to 0 (protected). Once the flash reports that protection has been programmed into it, both masks stop accepting bus writes. For any bank and flash address, the block answers combinationally whether a write to that sector is allowed.

The block also holds a three-bit setup register: address auto-increment, keyhole DMA enable and serial-wire debug enable. That register is guarded by an unlock word. Software first writes the unlock value to the key register, then writes the setup register. It then writes any other value to the key register to lock it again. A setup write made while the key is locked is dropped, and an error strobe reports it. A read-only signature register returns a 24-bit value supplied on an input port.

Top module: `flash_prot_regs`

## Requirements
- R1: After reset, both masks read 0xFFFFFFFF and the setup register reads 0x1, so `dbg_en`=1 and `auto_inc`=`dma_en`=0. At the same time `key_open`=0 and `setup_err`=0.
- R2: A write to offset 0 (bank 0 mask) or offset 1 (bank 1 mask) stores the old mask AND the write data. A bit that is already 0 stays 0, even when a 1 is written to it.
- R3: While `prot_locked_in`=1, writes to offsets 0 and 1 leave both masks unchanged.
- R4: A write of 0xF123F456 to offset 4 (key) sets `key_open` to 1 from the next cycle. A write of any other value to offset 4 clears it.
- R5: A write to offset 3 (setup) while `key_open`=1 loads data bits [2:0]. The outputs follow from the next cycle: bit 2 drives `auto_inc`, bit 1 drives `dma_en` and bit 0 drives `dbg_en`. A setup write does not relock the key.
- R6: A write to offset 3 while `key_open`=0 leaves the setup register unchanged. `setup_err` is 1 in the following cycle only.
- R7: `reg_rdata` is combinational on `reg_addr`:
  - offset 2 returns {8'h00, `sig_value`};
  - offset 3 returns the setup value with bits [31:3] zero;
  - offset 4 returns 0;
  - offsets 5 to 7 return 0.
- R8: `wr_allowed` is bit `query_addr[16:12]` of the mask selected by `query_bank` (0 selects bank 0), and it changes in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| prot_locked_in | input | 1 | Protection has been programmed into flash |
| sig_value | input | 24 | Signature value to expose |
| query_bank | input | 1 | Bank for the write-allowed query |
| query_addr | input | 17 | Flash byte address within the bank |
| wr_allowed | output | 1 | Queried sector is writable |
| key_open | output | 1 | Unlock key is currently latched |
| setup_err | output | 1 | One-cycle strobe for a dropped setup write |
| auto_inc | output | 1 | Address auto-increment enable |
| dma_en | output | 1 | Keyhole DMA enable |
| dbg_en | output | 1 | Serial-wire debug enable |

## Verification
A wrong mask bit shows on `wr_allowed` in the same cycle that its sector is queried, and on the mask readback in the cycle its offset is addressed. The bench therefore sweeps all 32 sectors of both banks after shaping the masks. A wrong lock state first shows on `key_open` one cycle after the key write. Its effect on the setup outputs, or on `setup_err`, follows one cycle after the next setup write. A model of every output is compared each cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/flash_prot_regs.sv
module flash_prot_regs #(
  parameter int          AW         = 3,
  parameter logic [31:0] UNLOCK_KEY = 32'hF123F456,
  parameter int          SEC_LSB    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        reg_addr,
  input  logic [31:0]          reg_wdata,
  input  logic                 reg_we,
  output logic [31:0]          reg_rdata,
  input  logic                 prot_locked_in,
  input  logic [23:0]          sig_value,
  input  logic                 query_bank,
  input  logic [SEC_LSB+4:0]   query_addr,
  output logic                 wr_allowed,
  output logic                 key_open,
  output logic                 setup_err,
  output logic                 auto_inc,
  output logic                 dma_en,
  output logic                 dbg_en
);
  localparam int SEL_W = 5;
  localparam logic [AW-1:0] OFS_PROT0 = AW'(0);
  localparam logic [AW-1:0] OFS_PROT1 = AW'(1);
  localparam logic [AW-1:0] OFS_SIG   = AW'(2);
  localparam logic [AW-1:0] OFS_SETUP = AW'(3);
  localparam logic [AW-1:0] OFS_KEY   = AW'(4);

  logic [31:0]      mask0, mask1;
  logic [2:0]       setup_q;
  logic [SEL_W-1:0] sec_sel;
  logic             unused_low_addr;

  wire wr_p0    = reg_we && reg_addr == OFS_PROT0 && !prot_locked_in;
  wire wr_p1    = reg_we && reg_addr == OFS_PROT1 && !prot_locked_in;
  wire wr_setup = reg_we && reg_addr == OFS_SETUP;
  wire wr_key   = reg_we && reg_addr == OFS_KEY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask0     <= '1;
      mask1     <= '1;
      setup_q   <= 3'b001;
      key_open  <= 1'b0;
      setup_err <= 1'b0;
    end else begin
      if (wr_p0) mask0 <= mask0 & reg_wdata;
      if (wr_p1) mask1 <= mask1 & reg_wdata;
      if (wr_key) key_open <= (reg_wdata == UNLOCK_KEY);
      if (wr_setup && key_open) setup_q <= reg_wdata[2:0];
      setup_err <= wr_setup && !key_open;
    end
  end

  assign {auto_inc, dma_en, dbg_en} = setup_q;

  assign sec_sel         = query_addr[SEC_LSB+SEL_W-1:SEC_LSB];
  assign unused_low_addr = ^query_addr[SEC_LSB-1:0];
  assign wr_allowed      = query_bank ? mask1[sec_sel] : mask0[sec_sel];

  always_comb begin
    unique case (reg_addr)
      OFS_PROT0: reg_rdata = mask0;
      OFS_PROT1: reg_rdata = mask1;
      OFS_SIG:   reg_rdata = {8'h00, sig_value};
      OFS_SETUP: reg_rdata = {29'd0, setup_q};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_prot_regs_chk.sv
module flash_prot_regs_chk #(
  parameter int          AW         = 3,
  parameter logic [31:0] UNLOCK_KEY = 32'hF123F456
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          reg_we,
  input logic [31:0]   reg_rdata,
  input logic          prot_locked_in,
  input logic          key_open,
  input logic          setup_err,
  input logic          auto_inc,
  input logic          dma_en,
  input logic          dbg_en,
  input logic [31:0]   mask0,
  input logic [31:0]   mask1
);
  p_mask_only_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask0 & ~$past(mask0)) == 32'd0) && ((mask1 & ~$past(mask1)) == 32'd0));

  p_mask_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prot_locked_in |=> $stable(mask0) && $stable(mask1));

  p_key_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(4) && reg_wdata == UNLOCK_KEY) |=> key_open);

  p_key_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(4) && reg_wdata != UNLOCK_KEY) |=> !key_open);

  p_locked_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(3) && !key_open) |=> setup_err && $stable({auto_inc, dma_en, dbg_en}));

  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    setup_err |-> $past(reg_we && reg_addr == AW'(3) && !key_open));

  p_setup_high_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(3)) |-> (reg_rdata[31:3] == 29'd0));

  p_key_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(4)) |-> (reg_rdata == 32'd0));
endmodule

bind flash_prot_regs flash_prot_regs_chk #(.AW(AW), .UNLOCK_KEY(UNLOCK_KEY)) u_chk (.*);

// File: tb/flash_prot_regs_test.sv
`timescale 1ns/1ps
module flash_prot_regs_test;
  localparam logic [31:0] KEY = 32'hF123F456;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic        prot_locked_in = 1'b0;
  logic [23:0] sig_value = 24'hA5C3E1;
  logic        query_bank = 1'b0;
  logic [16:0] query_addr = '0;
  logic        wr_allowed, key_open, setup_err, auto_inc, dma_en, dbg_en;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [31:0] m_mask [2];
  logic [2:0]  m_setup;
  bit          m_open, m_err;

  always #2.5 clk = ~clk;

  flash_prot_regs uut (.*);

  function automatic logic [31:0] exp_rdata(input logic [2:0] a);
    case (a)
      3'd0: return m_mask[0];
      3'd1: return m_mask[1];
      3'd2: return {8'h00, sig_value};
      3'd3: return {29'd0, m_setup};
      default: return 32'd0;
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic cmp_regs(input string tag);
    cmp(tag, "key_open", 32'(key_open), 32'(m_open));
    cmp(tag, "setup_err", 32'(setup_err), 32'(m_err));
    cmp(tag, "setup outs", 32'({auto_inc, dma_en, dbg_en}), 32'(m_setup));
  endtask

  task automatic step(input string tag, input logic [2:0] a, input logic [31:0] w, input bit we,
                      input bit lk = 1'b0, input bit qb = 1'b0, input logic [16:0] qa = '0);
    bit nerr;
    reg_addr = a; reg_wdata = w; reg_we = we; prot_locked_in = lk;
    query_bank = qb; query_addr = qa;
    #1;
    cmp(tag, "rdata", reg_rdata, exp_rdata(a));
    cmp(tag, "wr_allowed", 32'(wr_allowed), 32'(m_mask[qb][qa[16:12]]));
    @(posedge clk);
    nerr = we && a == 3'd3 && !m_open;
    if (we && a == 3'd0 && !lk) m_mask[0] = m_mask[0] & w;
    if (we && a == 3'd1 && !lk) m_mask[1] = m_mask[1] & w;
    if (we && a == 3'd3 && m_open) m_setup = w[2:0];
    if (we && a == 3'd4) m_open = (w == KEY);
    m_err = nerr;
    @(negedge clk);
    reg_we = 1'b0;
    cmp_regs(tag);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    m_mask[0] = '1; m_mask[1] = '1; m_setup = 3'b001; m_open = 1'b0; m_err = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    cmp_regs("R1");
    step("R1", 3'd0, 0, 1'b0);
    step("R1", 3'd1, 0, 1'b0);
    step("R1", 3'd3, 0, 1'b0);
    // R2: AND-only mask writes
    step("R2", 3'd0, 32'hFFFF_0FF0, 1'b1);
    step("R2", 3'd0, 32'hFFFF_FFFF, 1'b1);
    step("R2", 3'd1, 32'h7FFF_FFFE, 1'b1);
    step("R2", 3'd1, 32'hFFFF_FF7F, 1'b1);
    step("R2", 3'd0, 32'hFFFF_FFFF, 1'b0);
    // R8: sweep every sector of both banks
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 32; s++)
        step("R8", 3'(b), 0, 1'b0, 1'b0, 1'(b), 17'((s << 12) | (s * 37 % 4096)));
    // R6: locked setup write dropped
    step("R6", 3'd3, 32'h6, 1'b1);
    step("R6", 3'd3, 32'h6, 1'b0);
    // R4: wrong key, then right key
    step("R4", 3'd4, KEY ^ 32'h1, 1'b1);
    step("R4", 3'd4, KEY, 1'b1);
    step("R4", 3'd4, 0, 1'b0);
    // R5: setup writes while open
    step("R5", 3'd3, 32'h6, 1'b1);
    step("R5", 3'd3, 32'hFFFF_FFFF, 1'b1);
    step("R5", 3'd3, 32'h0000_0002, 1'b1);
    // R4: relock, R6: dropped again
    step("R4", 3'd4, 32'h0, 1'b1);
    step("R6", 3'd3, 32'h5, 1'b1);
    step("R6", 3'd3, 32'h5, 1'b1);
    step("R6", 3'd3, 0, 1'b0);
    // R3: masks frozen while protection programmed
    step("R3", 3'd0, 32'h0, 1'b1, 1'b1);
    step("R3", 3'd1, 32'h0, 1'b1, 1'b1, 1'b1, 17'h1F000);
    step("R3", 3'd0, 32'h0, 1'b0, 1'b0);
    step("R3", 3'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 17'h1F000);
    // R7: read-only and unmapped offsets
    sig_value = 24'h123456;
    step("R7", 3'd2, 32'hFFFF_FFFF, 1'b1);
    sig_value = 24'hFEDCBA;
    step("R7", 3'd2, 0, 1'b0);
    step("R7", 3'd3, 0, 1'b0);
    step("R7", 3'd4, 0, 1'b0);
    step("R7", 3'd5, 32'hDEAD_BEEF, 1'b1);
    step("R7", 3'd6, 0, 1'b0);
    step("R7", 3'd7, 0, 1'b0);
    step("R7", 3'd0, 0, 1'b0);
    step("R7", 3'd1, 0, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule